// File: doc/BRIEF.md
# E1 Transmit Frame Timing Generator

This block produces the position timing of a 2.048 Mb/s E1 transmit stream and builds its outgoing serial bit. Each clock is one bit time. A position counter steps through 8 bits per timeslot, 32 timeslots per frame and 16 frames per CRC-4 multiframe. Strobes decoded from that position tell the logic around the block which timeslot and frame are current, so that it can present payload, overhead and signaling bits in the right cycles.

The block samples the input that the current position calls for and merges it into the serial output. The overhead input supplies the international bit and the national bits of timeslot 0. A fixed alignment word fills the even frames. When channel-associated signaling is enabled, timeslot 16 takes signaling and extra bits. A rising edge on the frame-sync input forces a frame boundary. A rising edge on the multiframe-sync input forces the start of frame 0. With neither pulsed, the counters run free.

Bits inside a timeslot are numbered 1 to 8, and bit 1 is sent first. Timeslots are numbered 0 to 31, and frames 0 to 15.

Top module: `e1tx_timing`

## Requirements
- R1: The position advances one bit per clock: 8 bits per timeslot, 32 timeslots per frame and 16 frames, with frame 15 wrapping to frame 0. `ts_clk` is high during bits 1 to 4 of every timeslot and low during bits 5 to 8.
- R2: `sig_slot` is high for all 8 bits of timeslot 16 in every frame and low at all other times.
- R3: `align_frm` is high for the whole of every even-numbered frame and low for the whole of every odd-numbered frame.
- R4: `crc_mf_sync` is high during frames 0 to 7 and low during frames 8 to 15. `mf_bound` is high during frame 0 only.
- R5: `tx_data` presents, one clock later, the bit built for the position sampled at that clock edge. In every timeslot other than 0 and 16, that bit is `pay_in`.
- R6: Bit 1 of timeslot 0 carries `ovh_in` in every frame.
- R7: In even frames, bits 2 to 8 of timeslot 0 carry the fixed word 0011011, with bit 2 first.
- R8: In odd frames, timeslot 0 carries a 1 in bit 2, `pay_in` in bit 3, and `ovh_in` in bits 4 to 8.
- R9: When `cas_en` is high, timeslot 16 of frame 0 carries 0 in bits 1 to 4, `sig_in` in bit 6, and `xtra_in` in bits 5, 7 and 8.
- R10: When `cas_en` is high, timeslot 16 of frames 1 to 15 carries `sig_in`. When `cas_en` is low, timeslot 16 carries `pay_in`, and `sig_in` and `xtra_in` have no effect there.
- R11: A clock edge that sees `fsync_in` high, after it was low at the previous edge, moves the position to bit 1 of timeslot 0 of the next frame number, modulo 16.
- R12: A clock edge that sees `mfsync_in` high, after it was low at the previous edge, moves the position to bit 1 of timeslot 0 of frame 0. This takes priority over a frame-sync rise at the same edge.
- R13: While `rst` is high, the position is held at bit 1 of timeslot 0 of frame 0, and `tx_data` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| pay_in | input | 1 | Serial payload bit |
| fsync_in | input | 1 | Frame sync; a rise forces a frame boundary |
| mfsync_in | input | 1 | Multiframe sync; a rise forces frame 0 |
| ovh_in | input | 1 | International and national overhead bit |
| sig_in | input | 1 | Signaling bit for timeslot 16 |
| xtra_in | input | 1 | Extra bit for timeslot 16 of frame 0 |
| cas_en | input | 1 | Enables the signaling build of timeslot 16 |
| tx_data | output | 1 | Outgoing serial bit |
| ts_clk | output | 1 | Timeslot clock, high in bits 1 to 4 |
| align_frm | output | 1 | High during alignment (even) frames |
| sig_slot | output | 1 | High during timeslot 16 |
| crc_mf_sync | output | 1 | High during frames 0 to 7 |
| mf_bound | output | 1 | High during frame 0 |

## Verification
The assertions assume that every input holds one clean level across each rising edge. They also assume that the sync inputs are low while `rst` is high. Under those conditions, a sync rise that the design detects is the same event that `$rose` sees in the checker. The stimulus keeps to this: it changes every input only at falling edges, holds both syncs low through reset, and pulses each sync for a single clock. These pulses fall both on the natural boundary and at arbitrary mid-frame positions, including one edge where both syncs rise together.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;

    localparam int BITS_PER_SLOT   = 8;
    localparam int SLOTS_PER_FRAME = 32;
    localparam int FRAMES_PER_MF   = 16;
    localparam int SIG_SLOT        = 16;

    localparam int BIT_W  = $clog2(BITS_PER_SLOT);
    localparam int SLOT_W = $clog2(SLOTS_PER_FRAME);
    localparam int FRM_W  = $clog2(FRAMES_PER_MF);

    // Alignment word in bits [6:0], bit 2 of the timeslot at index 6; bit 7 is padding.
    localparam logic [7:0] FAS_WORD = 8'b0001_1011;

    typedef struct packed {
        logic [FRM_W-1:0]  frm;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;   // 0 = first transmitted bit (bit 1)
    } e1_pos_t;

    typedef enum logic [2:0] {
        SRC_PAY, SRC_OVH, SRC_SIG, SRC_XTRA, SRC_FAS, SRC_ONE, SRC_ZERO
    } src_e;

    function automatic logic [FRM_W-1:0] frame_after(input logic [FRM_W-1:0] f);
        return (f == FRM_W'(FRAMES_PER_MF - 1)) ? '0 : f + 1'b1;
    endfunction

    // Decide which input or constant fills the given bit position.
    function automatic src_e pick_src(input e1_pos_t p, input logic cas);
        src_e s;
        s = SRC_PAY;
        if (p.slot == '0) begin
            if (p.bitn == '0)                    s = SRC_OVH;
            else if (!p.frm[0])                  s = SRC_FAS;
            else if (p.bitn == BIT_W'(1))        s = SRC_ONE;
            else if (p.bitn == BIT_W'(2))        s = SRC_PAY;
            else                                 s = SRC_OVH;
        end else if (p.slot == SLOT_W'(SIG_SLOT) && cas) begin
            if (p.frm == '0) begin
                if (p.bitn < BIT_W'(4))          s = SRC_ZERO;
                else if (p.bitn == BIT_W'(5))    s = SRC_SIG;
                else                             s = SRC_XTRA;
            end else begin
                s = SRC_SIG;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/e1tx_pos_ctr.sv
module e1tx_pos_ctr
    import e1tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fs_in,
    input  logic    mf_in,
    output e1_pos_t pos
);

    logic    fs_q;
    logic    mf_q;
    e1_pos_t nxt;

    always_comb begin
        nxt = pos;
        if (mf_in && !mf_q) begin
            nxt = '0;
        end else if (fs_in && !fs_q) begin
            nxt.frm  = frame_after(pos.frm);
            nxt.slot = '0;
            nxt.bitn = '0;
        end else if (pos.bitn != BIT_W'(BITS_PER_SLOT - 1)) begin
            nxt.bitn = pos.bitn + 1'b1;
        end else begin
            nxt.bitn = '0;
            if (pos.slot != SLOT_W'(SLOTS_PER_FRAME - 1)) begin
                nxt.slot = pos.slot + 1'b1;
            end else begin
                nxt.slot = '0;
                nxt.frm  = frame_after(pos.frm);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            fs_q <= 1'b0;
            mf_q <= 1'b0;
        end else begin
            pos  <= nxt;
            fs_q <= fs_in;
            mf_q <= mf_in;
        end
    end

endmodule

// File: rtl/e1tx_bit_mux.sv
module e1tx_bit_mux
    import e1tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  e1_pos_t pos,
    input  logic    cas_en,
    input  logic    pay_in,
    input  logic    ovh_in,
    input  logic    sig_in,
    input  logic    xtra_in,
    output logic    tx_data
);

    src_e sel;
    logic bit_nxt;

    always_comb begin
        sel = pick_src(pos, cas_en);
        unique case (sel)
            SRC_PAY:  bit_nxt = pay_in;
            SRC_OVH:  bit_nxt = ovh_in;
            SRC_SIG:  bit_nxt = sig_in;
            SRC_XTRA: bit_nxt = xtra_in;
            SRC_FAS:  bit_nxt = FAS_WORD[3'd7 - pos.bitn];
            SRC_ONE:  bit_nxt = 1'b1;
            default:  bit_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tx_data <= 1'b0;
        else     tx_data <= bit_nxt;
    end

endmodule

// File: rtl/e1tx_strobes.sv
module e1tx_strobes
    import e1tx_pkg::*;
(
    input  e1_pos_t pos,
    output logic    ts_clk,
    output logic    align_frm,
    output logic    sig_slot,
    output logic    crc_mf_sync,
    output logic    mf_bound
);

    always_comb begin
        ts_clk      = pos.bitn < BIT_W'(BITS_PER_SLOT / 2);
        align_frm   = ~pos.frm[0];
        sig_slot    = pos.slot == SLOT_W'(SIG_SLOT);
        crc_mf_sync = pos.frm < FRM_W'(FRAMES_PER_MF / 2);
        mf_bound    = pos.frm == '0;
    end

endmodule

// File: rtl/e1tx_timing.sv
module e1tx_timing
    import e1tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pay_in,
    input  logic fsync_in,
    input  logic mfsync_in,
    input  logic ovh_in,
    input  logic sig_in,
    input  logic xtra_in,
    input  logic cas_en,
    output logic tx_data,
    output logic ts_clk,
    output logic align_frm,
    output logic sig_slot,
    output logic crc_mf_sync,
    output logic mf_bound
);

    e1_pos_t pos_w;

    e1tx_pos_ctr ctr_i (
        .clk   (clk),
        .rst   (rst),
        .fs_in (fsync_in),
        .mf_in (mfsync_in),
        .pos   (pos_w)
    );

    e1tx_bit_mux mux_i (
        .clk     (clk),
        .rst     (rst),
        .pos     (pos_w),
        .cas_en  (cas_en),
        .pay_in  (pay_in),
        .ovh_in  (ovh_in),
        .sig_in  (sig_in),
        .xtra_in (xtra_in),
        .tx_data (tx_data)
    );

    e1tx_strobes stb_i (
        .pos         (pos_w),
        .ts_clk      (ts_clk),
        .align_frm   (align_frm),
        .sig_slot    (sig_slot),
        .crc_mf_sync (crc_mf_sync),
        .mf_bound    (mf_bound)
    );

endmodule

// File: rtl/e1tx_timing_chk.sv
module e1tx_timing_chk
    import e1tx_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input e1_pos_t pos,
    input logic    cas_en,
    input logic    mfsync_in,
    input logic    tx_data,
    input logic    ts_clk,
    input logic    align_frm,
    input logic    sig_slot,
    input logic    crc_mf_sync,
    input logic    mf_bound
);

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (pos.frm == FRM_W'(FRAMES_PER_MF - 1) && pos.slot == SLOT_W'(SLOTS_PER_FRAME - 1)
         && pos.bitn == BIT_W'(BITS_PER_SLOT - 1)) |=> (pos == '0));

    assert_sig_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sig_slot) |-> ts_clk);

    assert_align_edge_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(align_frm) |-> ts_clk);

    assert_mf_in_crc_R4: assert property (@(posedge clk) disable iff (rst)
        mf_bound |-> crc_mf_sync);

    assert_crc_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(crc_mf_sync) |-> (ts_clk && align_frm));

    assert_fas_bit2_R7: assert property (@(posedge clk) disable iff (rst)
        (pos.slot == '0 && pos.bitn == BIT_W'(1) && !pos.frm[0]) |=> !tx_data);

    assert_nfas_bit2_R8: assert property (@(posedge clk) disable iff (rst)
        (pos.slot == '0 && pos.bitn == BIT_W'(1) && pos.frm[0]) |=> tx_data);

    assert_cas_mfas_R9: assert property (@(posedge clk) disable iff (rst)
        (cas_en && pos.frm == '0 && pos.slot == SLOT_W'(SIG_SLOT) && pos.bitn < BIT_W'(4))
        |=> !tx_data);

    assert_mf_jump_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(mfsync_in) |=> (pos == '0));

endmodule

bind e1tx_timing e1tx_timing_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .pos         (pos_w),
    .cas_en      (cas_en),
    .mfsync_in   (mfsync_in),
    .tx_data     (tx_data),
    .ts_clk      (ts_clk),
    .align_frm   (align_frm),
    .sig_slot    (sig_slot),
    .crc_mf_sync (crc_mf_sync),
    .mf_bound    (mf_bound)
);

// File: tb/e1tx_timing_tb_top.sv
`timescale 1ns/1ps
module e1tx_timing_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pay_in = 0, fsync_in = 0, mfsync_in = 0, ovh_in = 0, sig_in = 0, xtra_in = 0, cas_en = 1;
    logic tx_data, ts_clk, align_frm, sig_slot, crc_mf_sync, mf_bound;

    always #2.5 clk = ~clk;

    e1tx_timing dut_i (
        .clk(clk), .rst(rst), .pay_in(pay_in), .fsync_in(fsync_in), .mfsync_in(mfsync_in),
        .ovh_in(ovh_in), .sig_in(sig_in), .xtra_in(xtra_in), .cas_en(cas_en),
        .tx_data(tx_data), .ts_clk(ts_clk), .align_frm(align_frm), .sig_slot(sig_slot),
        .crc_mf_sync(crc_mf_sync), .mf_bound(mf_bound)
    );

    typedef struct { bit v; string tag; } exp_t;
    exp_t sb_q[$];

    int  vec = 0;
    int  bad = 0;
    bit  done = 0;
    int  m_f = 0, m_s = 0, m_b = 0;   // model position: frame, slot, bit index 0..7
    bit  fs_prev = 0, mf_prev = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d (frame %0d slot %0d bit %0d)",
                     tag, act, exp, m_f, m_s, m_b + 1);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    // Expected serial bit from the requirements, with the requirement it belongs to.
    function automatic exp_t build_bit(int f, int s, int b, bit cas, bit p, bit o, bit sg, bit x);
        exp_t e;
        bit [6:0] fas = 7'b0011011;
        e.v = p; e.tag = "R5";
        if (s == 0) begin
            if (b == 0) begin e.v = o; e.tag = "R6"; end
            else if (f % 2 == 0) begin e.v = fas[7 - b]; e.tag = "R7"; end
            else begin
                e.tag = "R8";
                if (b == 1) e.v = 1'b1;
                else if (b == 2) e.v = p;
                else e.v = o;
            end
        end else if (s == 16) begin
            if (!cas) begin e.v = p; e.tag = "R10"; end
            else if (f == 0) begin
                e.tag = "R9";
                if (b < 4) e.v = 1'b0;
                else if (b == 5) e.v = sg;
                else e.v = x;
            end else begin e.v = sg; e.tag = "R10"; end
        end
        return e;
    endfunction

    task automatic check_strobes(input string tag);
        chk(ts_clk == (m_b < 4), {"R1 ts_clk ", tag}, ts_clk, m_b < 4);
        chk(sig_slot == (m_s == 16), {"R2 sig_slot ", tag}, sig_slot, m_s == 16);
        chk(align_frm == (m_f % 2 == 0), {"R3 align_frm ", tag}, align_frm, m_f % 2 == 0);
        chk(crc_mf_sync == (m_f < 8), {"R4 crc_mf_sync ", tag}, crc_mf_sync, m_f < 8);
        chk(mf_bound == (m_f == 0), {"R4 mf_bound ", tag}, mf_bound, m_f == 0);
    endtask

    // Driver: one bit time, entered just after a falling edge.
    task automatic step(input bit fsv, input bit mfv, input string tag);
        exp_t e;
        check_strobes(tag);
        pay_in    = 1'($urandom);
        ovh_in    = 1'($urandom);
        sig_in    = 1'($urandom);
        xtra_in   = 1'($urandom);
        fsync_in  = fsv;
        mfsync_in = mfv;
        e = build_bit(m_f, m_s, m_b, cas_en, pay_in, ovh_in, sig_in, xtra_in);
        sb_q.push_back(e);
        if (mfv && !mf_prev) begin
            m_f = 0; m_s = 0; m_b = 0;
        end else if (fsv && !fs_prev) begin
            m_f = (m_f + 1) % 16; m_s = 0; m_b = 0;
        end else if (m_b < 7) begin
            m_b++;
        end else begin
            m_b = 0;
            if (m_s < 31) m_s++;
            else begin m_s = 0; m_f = (m_f + 1) % 16; end
        end
        fs_prev = fsv;
        mf_prev = mfv;
        @(negedge clk);
    endtask

    // Monitor: compares the serial output just after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (!rst && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            vec++;
            if (tx_data !== e.v) begin
                bad++;
                $display("FAIL %s tx_data: actual %0d expected %0d", e.tag, tx_data, e.v);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R13: reset state
        chk(tx_data == 1'b0, "R13 tx_data", tx_data, 0);
        check_strobes("R13");
        rst = 1'b0;

        // Free run with signaling enabled: two multiframes.
        for (int i = 0; i < 2 * 16 * 256; i++) step(0, 0, "");

        // Signaling disabled: one multiframe (R10).
        cas_en = 1'b0;
        for (int i = 0; i < 16 * 256; i++) step(0, 0, "R10");
        cas_en = 1'b1;

        // Frame sync rise at a mid-frame position (R11).
        for (int i = 0; i < 1000; i++) step(0, 0, "");
        step(1, 0, "");
        step(0, 0, "R11");
        for (int i = 0; i < 3000; i++) step(0, 0, "R11");

        // Frame sync pulsed on the natural boundary for several frames (R11).
        for (int k = 0; k < 4; k++) begin
            while (!(m_b == 7 && m_s == 31)) step(0, 0, "");
            step(1, 0, "");
            step(0, 0, "R11");
        end

        // Multiframe sync mid-frame, together with a frame sync rise (R12).
        for (int i = 0; i < 777; i++) step(0, 0, "");
        step(1, 1, "");
        step(0, 0, "R12");
        for (int i = 0; i < 16 * 256; i++) step(0, 0, "R12");

        // Multiframe sync alone, frame sync held low.
        for (int i = 0; i < 2500; i++) step(0, 0, "");
        step(0, 1, "");
        step(0, 0, "R12");
        for (int i = 0; i < 16 * 256; i++) step(0, 0, "R12");

        @(negedge clk);
        finish_run();
    end

endmodule